// File: doc/BRIEF.md
# Calendar Clock Freeze-and-Snapshot Register Bank

This block keeps a BCD calendar clock (seconds through century, plus a day-of-week count) and presents it to software through a small parallel register file. Two copies of the time exist. A hidden counter chain advances on every one-second tick. A visible copy is what the bus reads. Normally the visible copy follows the hidden chain, one cycle behind each tick.

Software sets a freeze bit in the control register before a multi-byte read. The visible copy then holds the instant at which the freeze was written, while the hidden chain keeps counting so no time is lost. After software clears the bit, a clear-time counter measured in system clocks must run out. Then every visible field is reloaded from the hidden chain on the same clock edge. This happens at once, without waiting for the next tick, so the refresh comes well within one second.

Top module: `rtc_freeze_bank`

## Requirements
- R1: After reset the freeze bit reads 0, seconds, minutes, hours, year and century read 00, and day-of-week, date and month read 01 (all BCD).
- R2: The register map is: address 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year, 7 control. While the freeze bit is 1, bus reads return the values that were visible at the edge where the freeze write took effect, and ticks do not change them.
- R3: The hidden chain keeps counting ticks during a freeze, and the refreshed copy shows every tick that arrived while frozen.
- R4: A refresh reloads all eight visible fields on one clock edge.
- R5: A write that clears the freeze bit on clock edge E0 makes the visible copy reload on edge E0+MIN_CLR_CYCLES+1, and not earlier, with no tick needed.
- R6: While unfrozen, after the clear-time counter has run out, a tick sampled on edge E increments the hidden chain on E, and the visible copy shows the new value after edge E+1. A freeze written on edge E+1 still captures that incremented value.
- R7: The chain rolls over seconds 59→00, minutes 59→00, hours 23→00, month 12→01, year 99→00 with a carry into century, and century 39→00.
- R8: The date rolls over after the month's last day: 30 for months 04, 06, 09 and 11, 31 for the other months, and for month 02, 29 if the year is a multiple of 4 (including 00) and 28 otherwise.
- R9: Day-of-week advances once per date change and counts 1 through 7, then back to 1.
- R10: A write to a time field while unfrozen loads both the hidden chain and the visible copy. A write while frozen loads the hidden chain only, and that value becomes visible at the next refresh.
- R11: The control register holds century (BCD) in bits 5:0, the freeze bit in bit 6, and reads 0 in bit 7. The freeze bit reads back as last written. Writes to it load century under the same rule as R10.
- R12: When a tick and a field write fall on the same edge, the chain first increments with all its carries, and then the written field takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable for one cycle |
| rdata_o | output | 8 | Read data from the visible copy, combinational on addr_i |

## Verification
Two sets of events can land on the same edge. The first is a tick and a bus write to a time field. The bench drives both in one cycle, writing minutes while seconds sit at 59, so a carry competes with the write. The expected result is the incremented chain with the written minutes in place. The second is the refresh that follows a tick and a freeze write on the next edge. The bench issues the freeze exactly one cycle after a tick and expects the snapshot to contain the incremented seconds.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

    localparam int FREEZE_BIT = 6;

    typedef enum logic [2:0] {
        REG_SEC  = 3'd0,
        REG_MIN  = 3'd1,
        REG_HOUR = 3'd2,
        REG_WDAY = 3'd3,
        REG_DATE = 3'd4,
        REG_MON  = 3'd5,
        REG_YEAR = 3'd6,
        REG_CTRL = 3'd7
    } rtc_reg_e;

    typedef struct packed {
        logic [7:0] cent;
        logic [7:0] year;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef struct packed {
        logic       carry;
        logic [7:0] val;
    } bcd_step_t;

    // Advance one BCD field; wraps to lo (with carry) once at or past hi.
    function automatic bcd_step_t bcd_adv(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
        bcd_step_t r;
        if (v >= hi) begin
            r.carry = 1'b1;
            r.val   = lo;
        end else begin
            r.carry = 1'b0;
            r.val   = (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
        end
        return r;
    endfunction

    // Year multiple of 4, decided on BCD digits directly.
    function automatic logic leap_bcd(input logic [7:0] y);
        if (y[4])
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m,
                                              input logic [7:0] y);
        case (m)
            8'h02:                      return leap_bcd(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] field_mask(input rtc_reg_e r);
        case (r)
            REG_SEC, REG_MIN: return 8'h7F;
            REG_HOUR, REG_DATE,
            REG_CTRL:         return 8'h3F;
            REG_WDAY:         return 8'h07;
            REG_MON:          return 8'h1F;
            default:          return 8'hFF;
        endcase
    endfunction

    function automatic rtc_time_t time_reset();
        rtc_time_t t;
        t      = '0;
        t.wday = 8'h01;
        t.date = 8'h01;
        t.mon  = 8'h01;
        return t;
    endfunction

    // Control address carries the century field.
    function automatic rtc_time_t set_field(input rtc_time_t t,
                                            input rtc_reg_e  r,
                                            input logic [7:0] d);
        rtc_time_t o;
        logic [7:0] v;
        o = t;
        v = d & field_mask(r);
        case (r)
            REG_SEC:  o.sec  = v;
            REG_MIN:  o.min  = v;
            REG_HOUR: o.hour = v;
            REG_WDAY: o.wday = v;
            REG_DATE: o.date = v;
            REG_MON:  o.mon  = v;
            REG_YEAR: o.year = v;
            default:  o.cent = v;
        endcase
        return o;
    endfunction

    function automatic logic [7:0] get_field(input rtc_time_t t,
                                             input rtc_reg_e  r);
        case (r)
            REG_SEC:  return t.sec;
            REG_MIN:  return t.min;
            REG_HOUR: return t.hour;
            REG_WDAY: return t.wday;
            REG_DATE: return t.date;
            REG_MON:  return t.mon;
            REG_YEAR: return t.year;
            default:  return t.cent;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_chain.sv
module rtc_cal_chain
    import rtc_snap_pkg::*;
#(
    parameter logic [7:0] CENT_LAST = 8'h39
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       wr_i,
    input  rtc_reg_e   sel_i,
    input  logic [7:0] data_i,
    output rtc_time_t  time_o
);

    rtc_time_t cur_q, nxt;
    bcd_step_t st_sec, st_min, st_hour, st_wday, st_date, st_mon, st_year, st_cent;
    logic c_min, c_hour, c_day, c_mon, c_year, c_cent;

    always_comb begin
        st_sec  = bcd_adv(cur_q.sec,  8'h00, 8'h59);
        st_min  = bcd_adv(cur_q.min,  8'h00, 8'h59);
        st_hour = bcd_adv(cur_q.hour, 8'h00, 8'h23);
        st_wday = bcd_adv(cur_q.wday, 8'h01, 8'h07);
        st_date = bcd_adv(cur_q.date, 8'h01, month_last(cur_q.mon, cur_q.year));
        st_mon  = bcd_adv(cur_q.mon,  8'h01, 8'h12);
        st_year = bcd_adv(cur_q.year, 8'h00, 8'h99);
        st_cent = bcd_adv(cur_q.cent, 8'h00, CENT_LAST);

        c_min  = tick_i & st_sec.carry;
        c_hour = c_min  & st_min.carry;
        c_day  = c_hour & st_hour.carry;
        c_mon  = c_day  & st_date.carry;
        c_year = c_mon  & st_mon.carry;
        c_cent = c_year & st_year.carry;

        nxt = cur_q;
        if (tick_i) nxt.sec  = st_sec.val;
        if (c_min)  nxt.min  = st_min.val;
        if (c_hour) nxt.hour = st_hour.val;
        if (c_day)  nxt.wday = st_wday.val;
        if (c_day)  nxt.date = st_date.val;
        if (c_mon)  nxt.mon  = st_mon.val;
        if (c_year) nxt.year = st_year.val;
        if (c_cent) nxt.cent = st_cent.val;

        // Written field overrides the incremented value.
        if (wr_i) nxt = set_field(nxt, sel_i, data_i);
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= time_reset();
        else     cur_q <= nxt;
    end

    assign time_o = cur_q;

    a_r7_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !wr_i && cur_q.sec == 8'h59) |=> (cur_q.sec == 8'h00));

    a_r7_sec_legal: assert property (@(posedge clk) disable iff (rst)
        (cur_q.sec <= 8'h59) && (cur_q.sec[3:0] <= 4'd9));

    a_r9_wday_range: assert property (@(posedge clk) disable iff (rst)
        (cur_q.wday >= 8'h01) && (cur_q.wday <= 8'h07));

endmodule

// File: rtl/rtc_clear_timer.sv
module rtc_clear_timer #(
    parameter int MIN_CLR_CYCLES = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic frz_i,
    output logic ok_o
);

    localparam int CW = $clog2(MIN_CLR_CYCLES + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(MIN_CLR_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                    cnt_q <= CNT_FULL;
        else if (frz_i)             cnt_q <= '0;
        else if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
    end

    assign ok_o = (cnt_q == CNT_FULL);

    // R5: clear window always restarts after a freeze is released.
    a_r5_not_ready_on_release: assert property (@(posedge clk) disable iff (rst)
        $fell(frz_i) |-> !ok_o);

endmodule

// File: rtl/rtc_vis_bank.sv
module rtc_vis_bank
    import rtc_snap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       copy_i,
    input  rtc_time_t  src_i,
    input  logic       wr_i,
    input  rtc_reg_e   sel_i,
    input  logic [7:0] data_i,
    input  logic       frz_i,
    output rtc_time_t  vis_o
);

    rtc_time_t vis_q, nxt;

    always_comb begin
        nxt = vis_q;
        if (copy_i)          nxt = src_i;
        if (wr_i && !frz_i)  nxt = set_field(nxt, sel_i, data_i);
    end

    always_ff @(posedge clk) begin
        if (rst) vis_q <= time_reset();
        else     vis_q <= nxt;
    end

    assign vis_o = vis_q;

    // R2: nothing reaches the visible copy while the freeze bit is set.
    a_r2_frozen_hold: assert property (@(posedge clk) disable iff (rst)
        frz_i |=> $stable(vis_q));

endmodule

// File: rtl/rtc_freeze_bank.sv
module rtc_freeze_bank
    import rtc_snap_pkg::*;
#(
    parameter int         MIN_CLR_CYCLES = 25000,
    parameter logic [7:0] CENT_LAST      = 8'h39
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    input  logic       we_i,
    output logic [7:0] rdata_o
);

    rtc_reg_e  sel;
    rtc_time_t hid_t, vis_t;
    logic      freeze_q, tick_d_q, pend_q, clr_ok, do_copy;

    assign sel = rtc_reg_e'(addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            freeze_q <= 1'b0;
            tick_d_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            tick_d_q <= tick_i;
            if (we_i && sel == REG_CTRL) freeze_q <= wdata_i[FREEZE_BIT];
            if (freeze_q)     pend_q <= 1'b1;
            else if (do_copy) pend_q <= 1'b0;
        end
    end

    assign do_copy = !freeze_q && clr_ok && (tick_d_q || pend_q);

    rtc_cal_chain #(.CENT_LAST(CENT_LAST)) chain_i (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .wr_i   (we_i),
        .sel_i  (sel),
        .data_i (wdata_i),
        .time_o (hid_t)
    );

    rtc_clear_timer #(.MIN_CLR_CYCLES(MIN_CLR_CYCLES)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .frz_i (freeze_q),
        .ok_o  (clr_ok)
    );

    rtc_vis_bank vis_i (
        .clk    (clk),
        .rst    (rst),
        .copy_i (do_copy),
        .src_i  (hid_t),
        .wr_i   (we_i),
        .sel_i  (sel),
        .data_i (wdata_i),
        .frz_i  (freeze_q),
        .vis_o  (vis_t)
    );

    always_comb begin
        if (sel == REG_CTRL) rdata_o = {1'b0, freeze_q, vis_t.cent[5:0]};
        else                 rdata_o = get_field(vis_t, sel);
    end

    a_r11_freeze_readback: assert property (@(posedge clk) disable iff (rst)
        (we_i && sel == REG_CTRL) |=> (rdata_o[FREEZE_BIT] == $past(wdata_i[FREEZE_BIT])
                                       || sel != REG_CTRL));

    a_r11_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == REG_CTRL) |-> (rdata_o[7] == 1'b0));

    // R4: a refresh never happens while the hidden chain is invisible to it.
    a_r4_copy_unfrozen: assert property (@(posedge clk) disable iff (rst)
        do_copy |=> (vis_t == $past(hid_t) || $past(we_i)));

endmodule

// File: tb/rtc_freeze_bank_tb_top.sv
module rtc_freeze_bank_tb_top;

    localparam int MINC = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_i;
    logic [2:0] addr_i;
    logic [7:0] wdata_i;
    logic       we_i;
    logic [7:0] rdata_o;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    int mi [8];   // hidden model, binary, index = address (7 = century)
    int mv [8];   // visible model
    bit mfrz;

    always #10 clk = ~clk;

    rtc_freeze_bank #(.MIN_CLR_CYCLES(MINC)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int mlen(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function void m_inc();
        mi[0]++;
        if (mi[0] > 59) begin
            mi[0] = 0; mi[1]++;
            if (mi[1] > 59) begin
                mi[1] = 0; mi[2]++;
                if (mi[2] > 23) begin
                    mi[2] = 0;
                    mi[3] = (mi[3] == 7) ? 1 : mi[3] + 1;
                    mi[4]++;
                    if (mi[4] > mlen(mi[5], mi[6])) begin
                        mi[4] = 1; mi[5]++;
                        if (mi[5] > 12) begin
                            mi[5] = 1; mi[6]++;
                            if (mi[6] > 99) begin
                                mi[6] = 0;
                                mi[7] = (mi[7] == 39) ? 0 : mi[7] + 1;
                            end
                        end
                    end
                end
            end
        end
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        if (a == 7) return {1'b0, mfrz, bcd(mv[7])[5:0]};
        return bcd(mv[a]);
    endfunction

    task automatic chk(input string req, input int a, input logic [7:0] exp);
        addr_i = 3'(a);
        #1;
        nvec++;
        if (rdata_o !== exp) begin
            nerr++;
            $display("FAIL %s addr %0d: got %h expected %h", req, a, rdata_o, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int a = 0; a < 8; a++) chk(req, a, exp_rd(a));
    endtask

    // Field value as binary into model; write is applied to hidden model,
    // and to the visible model when not frozen before the write.
    function void m_write(input int a, input logic [7:0] d);
        int v;
        bit old;
        old = mfrz;
        if (a == 7) v = (d[5:4] * 10) + d[3:0];
        else        v = (d[7:4] * 10) + d[3:0];
        mi[a] = v;
        if (!old) mv[a] = v;
        if (a == 7) mfrz = d[6];
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        addr_i = 3'(a); wdata_i = d; we_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0;
        m_write(a, d);
    endtask

    task automatic tick();
        @(negedge clk); tick_i = 1'b1;
        @(negedge clk); tick_i = 1'b0;
        @(negedge clk);
        m_inc();
        if (!mfrz) mv = mi;
    endtask

    task automatic set_time(input int y, input int mo, input int dt, input int wd,
                            input int h, input int mn, input int s);
        wr(6, bcd(y)); wr(5, bcd(mo)); wr(4, bcd(dt)); wr(3, bcd(wd));
        wr(2, bcd(h)); wr(1, bcd(mn)); wr(0, bcd(s));
    endtask

    // Clears freeze (keeping century) and waits for the gated refresh.
    task automatic unfreeze_wait();
        wr(7, {2'b00, bcd(mi[7])[5:0]});
        repeat (MINC + 1) @(negedge clk);
        mv = mi;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] snap;
        seed = $urandom(32'd1746);
        rst = 1'b1; tick_i = 0; we_i = 0; addr_i = 0; wdata_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mi = '{0, 0, 0, 1, 1, 1, 0, 0};
        mv = mi; mfrz = 0;

        // R1 reset values
        chk_all("R1");

        // R7 R9 full rollover including century
        wr(7, bcd(39));
        set_time(99, 12, 31, 7, 23, 59, 59);
        tick();
        chk_all("R7");
        chk("R9", 3, 8'h01);
        chk("R7", 7, 8'h00);

        // R8 leap and non-leap February
        set_time(24, 2, 28, 3, 23, 59, 59);
        tick();
        chk("R8", 4, 8'h29); chk("R8", 5, 8'h02);
        set_time(23, 2, 28, 3, 23, 59, 59);
        tick();
        chk("R8", 4, 8'h01); chk("R8", 5, 8'h03);
        set_time(21, 4, 30, 2, 23, 59, 59);
        tick();
        chk("R8", 4, 8'h01); chk("R8", 5, 8'h05);
        chk("R9", 3, 8'h03);

        // R6 refresh one cycle after the tick
        set_time(30, 6, 10, 4, 10, 20, 30);
        @(negedge clk); tick_i = 1; @(negedge clk); tick_i = 0;
        chk("R6", 0, 8'h30);           // after E: visible not yet moved
        @(negedge clk);
        chk("R6", 0, 8'h31);           // after E+1
        m_inc(); mv = mi;

        // R6 R2 freeze written the cycle after a tick captures it
        @(negedge clk); tick_i = 1; @(negedge clk); tick_i = 0;
        addr_i = 3'd7; wdata_i = 8'h40 | {2'b00, bcd(mi[7])[5:0]}; we_i = 1;
        @(negedge clk); we_i = 0;
        m_inc(); mv = mi; mfrz = 1;
        snap = bcd(mv[0]);
        chk("R6", 0, 8'h32);
        chk("R11", 7, {2'b01, bcd(mi[7])[5:0]});

        // R2 R3 ticks during freeze do not reach the visible copy
        for (int k = 0; k < 5; k++) tick();
        chk_all("R2");
        chk("R2", 0, snap);

        // R10 write while frozen reaches hidden only
        wr(2, bcd(15));
        chk("R10", 2, 8'h10);

        // R5 gated refresh timing, R4 all fields together, R3 ticks kept
        wr(7, {2'b00, bcd(mi[7])[5:0]});
        repeat (MINC) @(negedge clk);
        chk("R5", 0, snap);
        chk("R5", 2, 8'h10);
        @(negedge clk);
        mv = mi;
        chk("R3", 0, 8'h37);
        chk_all("R4");

        // R12 tick and minutes write on same edge while seconds at 59
        set_time(30, 6, 10, 4, 10, 20, 59);
        @(negedge clk);
        tick_i = 1; we_i = 1; addr_i = 3'd1; wdata_i = 8'h45;
        @(negedge clk); tick_i = 0; we_i = 0;
        @(negedge clk);
        m_inc(); mi[1] = 45; mv = mi;
        chk("R12", 0, 8'h00);
        chk("R12", 1, 8'h45);
        chk("R12", 2, 8'h10);

        // R10 write while unfrozen visible at once
        wr(6, bcd(57));
        chk("R10", 6, 8'h57);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op, a, v;
            op = int'($urandom % 10);
            if (op < 5) tick();
            else if (op < 8) begin
                a = int'($urandom % 7);
                case (a)
                    0, 1: v = int'($urandom % 60);
                    2: v = int'($urandom % 24);
                    3: v = 1 + int'($urandom % 7);
                    4: v = 1 + int'($urandom % 28);
                    5: v = 1 + int'($urandom % 12);
                    default: v = int'($urandom % 100);
                endcase
                wr(a, bcd(v));
            end else if (op == 8) begin
                if (mfrz) unfreeze_wait();
                else wr(7, 8'h40 | {2'b00, bcd(mi[7])[5:0]});
            end else chk_all(mfrz ? "R2" : "R10");
        end
        if (mfrz) unfreeze_wait();
        chk_all("R3");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule